// File: doc/BRIEF.md
# Interrupt Cause and Mask Group

This block is a single group of a peripheral interrupt controller. It holds a sticky cause register that hardware events set, a mask register that gates which causes reach the summary interrupt, an abort-enable register that picks which causes raise a DMA-abort request, and a plain control register. All of it is reached through a simple register bus.

Software acknowledges causes and unmasks sources by writing zeros to the bits it wants to act on. Bits written as one are left alone. This lets one agent touch its own bits without a read-modify-write that could race with another agent. A separate alias address forces cause bits with write-one, which is useful for testing the interrupt path. A controller with several groups instances this block once per group.

Top module: `irq_grp`

## Requirements
- R1: After reset, the cause register is all zeros, the mask is all ones, the abort-enable register and the control register are zeros, and `irq_out` and `abort_req` are low.
- R2: A high level on `evt_in[i]` at a clock edge sets cause bit i. The bit stays set after the event drops, until software clears it.
- R3: A write to address 0 (cause) clears each cause bit written as 0 and leaves each bit written as 1 unchanged.
- R4: A write to address 1 (cause-set alias) sets each cause bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A write to address 2 (mask) loads the full value, where 1 means masked. Reading address 2 returns the mask.
- R6: A write to address 3 (mask-clear alias) clears each mask bit written as 0 and leaves each bit written as 1 unchanged.
- R7: `irq_out` is high exactly when some cause bit is set whose mask bit is 0.
- R8: Address 4 holds the abort-enable register, where 1 enables abort for that source. `abort_req` is high exactly when some cause bit is set whose abort-enable bit is 1.
- R9: When an event and a clearing cause write hit the same bit at the same edge, the event wins and the bit ends up set.
- R10: A read returns its data on `bus_rdata` one clock after the request. Addresses 0 and 1 both return the cause register, and addresses 2 and 3 both return the mask.
- R11: Address 5 is a control register that stores and returns the full written value.
- R12: Addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, registered |
| evt_in | input | WIDTH | Level event inputs, one per source |
| irq_out | output | 1 | Summary interrupt |
| abort_req | output | 1 | DMA-abort request |

## Verification
A write or an event is taken at one edge, and the register state it produces is visible from the next edge. `irq_out` and `abort_req` are combinational from that state, so they are due in the same cycle as the updated state. Read data passes through one more register and appears one edge after the read request. The bench drives every input at the falling edge. It samples the outputs at the falling edge after the edge where each result is due, so each check sees exactly one register stage per step.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

    localparam int ADDR_W = 3;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CAUSE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CSET  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MCLR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_ABORT = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;

    typedef enum logic [2:0] {
        SEL_CAUSE,
        SEL_MASK,
        SEL_ABORT,
        SEL_CTRL,
        SEL_NONE
    } rd_sel_e;

    typedef struct packed {
        logic    cause_wr;
        logic    cset_wr;
        logic    mask_wr;
        logic    mclr_wr;
        logic    abort_wr;
        logic    ctrl_wr;
        logic    rd;
        rd_sel_e rd_sel;
    } strobe_t;

    // per-bit next state of a cause bit: event > set > clear > hold
    function automatic logic cause_next(input logic cur, input logic evt,
                                        input logic set_hit, input logic clr_hit);
        if (evt)          return 1'b1;
        else if (set_hit) return 1'b1;
        else if (clr_hit) return 1'b0;
        else              return cur;
    endfunction

endpackage

// File: rtl/irq_grp_decode.sv
module irq_grp_decode
    import irq_grp_pkg::*;
(
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output strobe_t           stb
);
    logic wr;
    assign wr = sel & we;

    always_comb begin
        stb          = '0;
        stb.rd       = sel & ~we;
        stb.cause_wr = wr && (addr == A_CAUSE);
        stb.cset_wr  = wr && (addr == A_CSET);
        stb.mask_wr  = wr && (addr == A_MASK);
        stb.mclr_wr  = wr && (addr == A_MCLR);
        stb.abort_wr = wr && (addr == A_ABORT);
        stb.ctrl_wr  = wr && (addr == A_CTRL);
        case (addr)
            A_CAUSE, A_CSET: stb.rd_sel = SEL_CAUSE;
            A_MASK,  A_MCLR: stb.rd_sel = SEL_MASK;
            A_ABORT:         stb.rd_sel = SEL_ABORT;
            A_CTRL:          stb.rd_sel = SEL_CTRL;
            default:         stb.rd_sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/irq_grp_cause.sv
module irq_grp_cause
    import irq_grp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] evt,
    input  logic             clr_wr,
    input  logic             set_wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] cause
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= cause_next(q, evt[i], set_wr & wdata[i], clr_wr & ~wdata[i]);
        end
        assign cause[i] = q;
    end
endmodule

// File: rtl/irq_grp_cfg.sv
module irq_grp_cfg
    import irq_grp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          stb,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] abort_en,
    output logic [WIDTH-1:0] ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask     <= '1;
            abort_en <= '0;
            ctrl     <= '0;
        end else begin
            if (stb.mask_wr)      mask <= wdata;
            else if (stb.mclr_wr) mask <= mask & wdata;
            if (stb.abort_wr)     abort_en <= wdata;
            if (stb.ctrl_wr)      ctrl <= wdata;
        end
    end
endmodule

// File: rtl/irq_grp.sv
module irq_grp
    import irq_grp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  evt_in,
    output logic              irq_out,
    output logic              abort_req
);
    strobe_t          stb;
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] abort_q;
    logic [WIDTH-1:0] ctrl_q;
    logic [WIDTH-1:0] rd_mux;

    irq_grp_decode u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .stb  (stb)
    );

    irq_grp_cause #(.WIDTH(WIDTH)) u_cause (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_in),
        .clr_wr (stb.cause_wr),
        .set_wr (stb.cset_wr),
        .wdata  (bus_wdata),
        .cause  (cause_q)
    );

    irq_grp_cfg #(.WIDTH(WIDTH)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .stb      (stb),
        .wdata    (bus_wdata),
        .mask     (mask_q),
        .abort_en (abort_q),
        .ctrl     (ctrl_q)
    );

    always_comb begin
        case (stb.rd_sel)
            SEL_CAUSE: rd_mux = cause_q;
            SEL_MASK:  rd_mux = mask_q;
            SEL_ABORT: rd_mux = abort_q;
            SEL_CTRL:  rd_mux = ctrl_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (stb.rd) bus_rdata <= rd_mux;
    end

    assign irq_out   = |(cause_q & ~mask_q);
    assign abort_req = |(cause_q & abort_q);
endmodule

// File: rtl/irq_grp_chk.sv
module irq_grp_chk
    import irq_grp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  evt_in,
    input logic              irq_out,
    input logic              abort_req,
    input logic [WIDTH-1:0]  cause_q,
    input logic [WIDTH-1:0]  mask_q
);
    logic wr;
    assign wr = bus_sel & bus_we;

    // R2, R9: every sampled event bit is set afterwards
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((cause_q & $past(evt_in)) == $past(evt_in)));

    assert_cause_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == A_CAUSE && evt_in == '0)
        |=> (cause_q == ($past(cause_q) & $past(bus_wdata))));

    assert_mask_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == A_MCLR)
        |=> (mask_q == ($past(mask_q) & $past(bus_wdata))));

    // R4 and R7: forcing an unmasked cause raises the interrupt
    assert_force_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == A_CSET && (bus_wdata & ~mask_q) != '0) |=> irq_out);

    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == A_ABORT && (bus_wdata & cause_q) != '0) |=> abort_req);

    assert_alias_read_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == A_MCLR) |=> (bus_rdata == $past(mask_q)));
endmodule

bind irq_grp irq_grp_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_in    (evt_in),
    .irq_out   (irq_out),
    .abort_req (abort_req),
    .cause_q   (cause_q),
    .mask_q    (mask_q)
);

// File: tb/irq_grp_bench.sv
module irq_grp_bench;
    localparam int W = 32;

    typedef struct packed {
        logic [2:0]   wa;
        logic [W-1:0] wd;
        logic [W-1:0] ev;
        logic [2:0]   ra;
        logic [W-1:0] er;
        logic         ei;
        logic         ea;
    } vec_t;

    // each step: write wa/wd with event ev, then read ra; wa=7 is an unmapped write
    localparam vec_t VECS [10] = '{
        '{3'd1, 32'h0000_00F0, 32'h0, 3'd0, 32'h0000_00F0, 1'b0, 1'b0}, // R4 set, masked
        '{3'd3, 32'hFFFF_FF0F, 32'h0, 3'd2, 32'hFFFF_FF0F, 1'b1, 1'b0}, // R6 R7 unmask
        '{3'd0, 32'hFFFF_FF3F, 32'h0, 3'd1, 32'h0000_0030, 1'b1, 1'b0}, // R3 clear, R10 alias read
        '{3'd4, 32'h0000_0020, 32'h0, 3'd4, 32'h0000_0020, 1'b1, 1'b1}, // R8 abort
        '{3'd7, 32'hFFFF_FFFF, 32'h0001_0000, 3'd0, 32'h0001_0030, 1'b1, 1'b1}, // R2 event
        '{3'd2, 32'hFFFF_FFFF, 32'h0, 3'd3, 32'hFFFF_FFFF, 1'b0, 1'b1}, // R5 full mask
        '{3'd0, 32'h0000_0000, 32'h0000_0001, 3'd0, 32'h0000_0001, 1'b0, 1'b0}, // R9 event wins
        '{3'd5, 32'hA5A5_0003, 32'h0, 3'd5, 32'hA5A5_0003, 1'b0, 1'b0}, // R11 control
        '{3'd7, 32'hFFFF_FFFF, 32'h0, 3'd7, 32'h0000_0000, 1'b0, 1'b0}, // R12 unmapped
        '{3'd2, 32'hFFFF_FFFE, 32'h0, 3'd0, 32'h0000_0001, 1'b1, 1'b0}  // R5 R7
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] evt_in = '0;
    logic         irq_out;
    logic         abort_req;
    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    irq_grp #(.WIDTH(W)) u_irq_grp (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_in    (evt_in),
        .irq_out   (irq_out),
        .abort_req (abort_req)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one write (plus events) taken at the next rising edge
    task automatic do_write(input logic [2:0] a, input logic [W-1:0] d, input logic [W-1:0] e);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; evt_in = e;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; evt_in = '0;
    endtask

    // read request at one edge, data sampled at the falling edge after it
    task automatic do_read(input logic [2:0] a, output logic [W-1:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [W-1:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_out", {31'b0, irq_out}, 32'h0);
        check("R1 abort_req", {31'b0, abort_req}, 32'h0);
        do_read(3'd0, rd); check("R1 cause", rd, 32'h0);
        do_read(3'd2, rd); check("R1 mask", rd, 32'hFFFF_FFFF);
        do_read(3'd4, rd); check("R1 abort", rd, 32'h0);
        do_read(3'd5, rd); check("R1 ctrl", rd, 32'h0);

        foreach (VECS[i]) begin
            do_write(VECS[i].wa, VECS[i].wd, VECS[i].ev);
            check($sformatf("vec%0d irq R7", i), {31'b0, irq_out}, {31'b0, VECS[i].ei});
            check($sformatf("vec%0d abort R8", i), {31'b0, abort_req}, {31'b0, VECS[i].ea});
            do_read(VECS[i].ra, rd);
            check($sformatf("vec%0d read R10", i), rd, VECS[i].er);
        end

        // R2: one-cycle event pulse stays sticky; cause now 0x1
        do_write(3'd7, 32'h0, 32'h8000_0000);
        repeat (3) @(negedge clk);
        do_read(3'd0, rd); check("R2 sticky", rd, 32'h8000_0001);

        // R4: zeros written to the set alias change nothing
        do_write(3'd1, 32'h0, 32'h0);
        do_read(3'd0, rd); check("R4 zero no effect", rd, 32'h8000_0001);

        // R12: unmapped write leaves all registers
        do_write(3'd6, 32'h0, 32'h0);
        do_read(3'd2, rd); check("R12 mask kept", rd, 32'hFFFF_FFFE);
        do_read(3'd5, rd); check("R12 ctrl kept", rd, 32'hA5A5_0003);
        do_read(3'd6, rd); check("R12 read zero", rd, 32'h0);

        // R3: clear all, irq drops (R7)
        do_write(3'd0, 32'h0, 32'h0);
        check("R3 irq drop", {31'b0, irq_out}, 32'h0);
        do_read(3'd1, rd); check("R3 all clear", rd, 32'h0);

        // R9: event on bit 3 with set and full clear on others
        do_write(3'd0, 32'h0, 32'h0000_0008);
        do_read(3'd0, rd); check("R9 event vs clear", rd, 32'h0000_0008);

        // R10: read data holds when no read is requested
        do_write(3'd7, 32'h0, 32'h0);
        check("R10 hold", bus_rdata, 32'h0000_0008);

        // R1: reset again restores defaults
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        do_read(3'd3, rd); check("R1 mask after rst", rd, 32'hFFFF_FFFF);
        do_read(3'd0, rd); check("R1 cause after rst", rd, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule